// File: doc/BRIEF.md
# Masked-Write GPIO Bank Controller

This block controls one bank of up to 32 general-purpose pins from a plain 32-bit register bus with address, write enable, write data and read data. For each pin it holds an output value, a direction bit and an output-enable bit. It also returns the synchronized level of every pin. The pad tristate buffers sit outside the block. The block exports an output-value vector and a drive-enable vector for them. Interrupt detection is handled by a separate block.

Software updates output pins through two write-only half-bank windows. In each window the upper half-word of the write data is a per-pin keep mask and the lower half-word is the new value. A single pin can therefore be set or cleared in one bus write, with no read-modify-write and no race against other writers. The number of implemented pins and the bank index are parameters. The bank index places the register addresses. In bank 0, pins 7 and 8 are fixed as outputs.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous reset, every output value bit, every output-enable bit and every `pin_oe` bit is 0. Every direction bit is 0 except the fixed-output bits of R7.
- R2: A write to byte address 8*BANK_ID updates pins 0..15. For each bit i, if write-data bit 16+i is 0, pin i takes write-data bit i. The new value appears on `pin_out` in the cycle after the write edge.
- R3: In a window write, a pin whose keep bit (write-data bit 16+i) is 1 keeps its previous output value. With no write, `pin_out` and `pin_oe` do not change.
- R4: A write to byte address 8*BANK_ID+4 applies the same keep/value rule to pins 16..31. Keep bit 16+i and value bit i apply to pin 16+i.
- R5: The direction register is at 0x204+0x40*BANK_ID and the output-enable register is at 0x208+0x40*BANK_ID. Both can be written and read back. A direction bit of 1 selects output.
- R6: `pin_oe[i]` is 1 exactly when direction bit i and output-enable bit i are both 1.
- R7: When BANK_ID is 0, direction bits 7 and 8 always read 1. A write of 0 to either bit leaves it at 1.
- R8: The read-only level register at 0x060+4*BANK_ID returns the `pin_in` levels through a two-flop synchronizer. A level applied before edge k is returned in `rd_data` after edge k+2.
- R9: Bits at or above NUM_PINS always read 0 in every register and are never stored.
- R10: Both window addresses read 0. Writes to any address that is not mapped change nothing, and reads from such addresses return 0.
- R11: `rd_data` is registered. It shows the register selected by `addr` at one clock edge after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pin_out | output | NUM_PINS | Output value for each pad |
| pin_oe | output | NUM_PINS | Drive enable for each pad |

## Verification
The bench builds the block with BANK_ID 0 and NUM_PINS 22. Bank 0 brings the fixed-output pins 7 and 8 within reach. The 22-pin width leaves the top ten bits unimplemented, so high-window writes, all-ones register writes and all-ones pin levels can show that those bits stay zero. Because the addresses follow bank 0, an address that would be a window in bank 1 (0x00C) also serves as an unmapped-address case.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_WIN_LO,
    SEL_WIN_HI,
    SEL_PIN_LVL,
    SEL_DIR,
    SEL_OE
  } sel_e;

  function automatic logic [WORD_W-1:0] win_lo_addr(int unsigned bank);
    return WORD_W'(8 * bank);
  endfunction

  function automatic logic [WORD_W-1:0] win_hi_addr(int unsigned bank);
    return WORD_W'(8 * bank + 4);
  endfunction

  function automatic logic [WORD_W-1:0] lvl_addr(int unsigned bank);
    return WORD_W'(32'h060 + 4 * bank);
  endfunction

  function automatic logic [WORD_W-1:0] dir_addr(int unsigned bank);
    return WORD_W'(32'h204 + 32'h40 * bank);
  endfunction

  function automatic logic [WORD_W-1:0] oe_addr(int unsigned bank);
    return WORD_W'(32'h208 + 32'h40 * bank);
  endfunction

  function automatic logic [WORD_W-1:0] impl_mask(int unsigned npins);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      if (i < int'(npins)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] fixed_out_mask(int unsigned bank,
                                                       int unsigned npins);
    logic [WORD_W-1:0] m;
    m = '0;
    if (bank == 0) begin
      if (npins > 7) m[7] = 1'b1;
      if (npins > 8) m[8] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
`timescale 1ns/1ps
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned BANK_ID = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);

  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(win_lo_addr(BANK_ID));
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(win_hi_addr(BANK_ID));
  localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(lvl_addr(BANK_ID));
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(dir_addr(BANK_ID));
  localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(oe_addr(BANK_ID));

  always_comb begin
    if      (addr == A_LO)  sel = SEL_WIN_LO;
    else if (addr == A_HI)  sel = SEL_WIN_HI;
    else if (addr == A_LVL) sel = SEL_PIN_LVL;
    else if (addr == A_DIR) sel = SEL_DIR;
    else if (addr == A_OE)  sel = SEL_OE;
    else                    sel = SEL_NONE;
  end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_out_regs.sv
`timescale 1ns/1ps
module gpio_out_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] dout_q,
  output logic [WORD_W-1:0] dir_q,
  output logic [WORD_W-1:0] oe_q,
  output logic [WORD_W-1:0] drive_q
);

  localparam logic [WORD_W-1:0] IMPL  = impl_mask(NUM_PINS);
  localparam logic [WORD_W-1:0] FIXED = fixed_out_mask(BANK_ID, NUM_PINS);
  localparam int unsigned       NHALF = WORD_W / HALF_W;

  logic [WORD_W-1:0] dout_nx;
  logic [WORD_W-1:0] dir_nx;
  logic [WORD_W-1:0] oe_nx;

  // One keep/value merge per half-bank window.
  for (genvar h = 0; h < int'(NHALF); h++) begin : g_half
    localparam sel_e WIN = (h == 0) ? SEL_WIN_LO : SEL_WIN_HI;
    logic [HALF_W-1:0] keep;
    logic [HALF_W-1:0] val;
    logic [HALF_W-1:0] half_nx;

    assign keep = wr_data[WORD_W-1:HALF_W];
    assign val  = wr_data[HALF_W-1:0];

    always_comb begin
      half_nx = dout_q[h*HALF_W +: HALF_W];
      if (wr_en && sel == WIN)
        half_nx = (half_nx & keep) | (val & ~keep);
    end

    assign dout_nx[h*HALF_W +: HALF_W] = half_nx;
  end

  always_comb begin
    dir_nx = dir_q;
    oe_nx  = oe_q;
    if (wr_en && sel == SEL_DIR) dir_nx = (wr_data & IMPL) | FIXED;
    if (wr_en && sel == SEL_OE)  oe_nx  = wr_data & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dir_q   <= FIXED;
      oe_q    <= '0;
      drive_q <= '0;
    end else begin
      dout_q  <= dout_nx & IMPL;
      dir_q   <= dir_nx;
      oe_q    <= oe_nx;
      drive_q <= dir_nx & oe_nx;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_ID  = 0,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  sel_e              sel;
  logic [WORD_W-1:0] dout_q;
  logic [WORD_W-1:0] dir_q;
  logic [WORD_W-1:0] oe_q;
  logic [WORD_W-1:0] drive_q;
  logic [NUM_PINS-1:0] lvl_sync;
  logic [WORD_W-1:0] lvl_word;

  gpio_bank_decode #(.ADDR_W(ADDR_W), .BANK_ID(BANK_ID)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  gpio_out_regs #(.NUM_PINS(NUM_PINS), .BANK_ID(BANK_ID)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .sel     (sel),
    .wr_data (wr_data),
    .dout_q  (dout_q),
    .dir_q   (dir_q),
    .oe_q    (oe_q),
    .drive_q (drive_q)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl_sync)
  );

  assign lvl_word = WORD_W'(lvl_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (sel)
        SEL_PIN_LVL: rd_data <= lvl_word;
        SEL_DIR:     rd_data <= dir_q;
        SEL_OE:      rd_data <= oe_q;
        default:     rd_data <= '0;
      endcase
    end
  end

  assign pin_out = dout_q[NUM_PINS-1:0];
  assign pin_oe  = drive_q[NUM_PINS-1:0];

endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_ID  = 0,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic [WORD_W-1:0]   rd_data,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [WORD_W-1:0]   dir_q
);

  localparam logic [WORD_W-1:0] IMPL  = impl_mask(NUM_PINS);
  localparam logic [WORD_W-1:0] FIXED = fixed_out_mask(BANK_ID, NUM_PINS);

  logic is_win;
  logic is_mapped;

  assign is_win = (addr == ADDR_W'(win_lo_addr(BANK_ID))) ||
                  (addr == ADDR_W'(win_hi_addr(BANK_ID)));
  assign is_mapped = is_win ||
                     (addr == ADDR_W'(lvl_addr(BANK_ID))) ||
                     (addr == ADDR_W'(dir_addr(BANK_ID))) ||
                     (addr == ADDR_W'(oe_addr(BANK_ID)));

  // R3: without a write, the pad-facing outputs hold
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

  // R10: writes outside the map leave outputs alone
  assert_unmapped_wr_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_mapped) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R10: windows are write-only and read back zero
  assert_win_read_R10: assert property (@(posedge clk) disable iff (rst)
    is_win |=> (rd_data == '0));

  // R6: a pin may drive only while configured as output
  assert_drive_dir_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~dir_q[NUM_PINS-1:0]) == '0);

  // R7: fixed-output direction bits never clear
  assert_fixed_dir_R7: assert property (@(posedge clk) disable iff (rst)
    (dir_q & FIXED) == FIXED);

  // R9: unimplemented bit positions read zero
  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~IMPL) == '0);

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .BANK_ID  (BANK_ID),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_data (rd_data),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .dir_q   (dir_q)
);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;

  localparam int unsigned NP  = 22;
  localparam int unsigned AW  = 12;
  localparam logic [AW-1:0] A_LO  = 12'h000;
  localparam logic [AW-1:0] A_HI  = 12'h004;
  localparam logic [AW-1:0] A_LVL = 12'h060;
  localparam logic [AW-1:0] A_DIR = 12'h204;
  localparam logic [AW-1:0] A_OE  = 12'h208;
  localparam logic [AW-1:0] A_UNM = 12'h100;
  localparam logic [AW-1:0] A_B1W = 12'h00C;

  typedef struct packed {
    logic [AW-1:0] waddr;
    logic [31:0]   wdata;
    logic [AW-1:0] raddr;
    logic [31:0]   rexp;
    logic [NP-1:0] pexp;
    logic [NP-1:0] oexp;
    logic [7:0]    req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    // R2: full low write
    '{A_LO,  32'h0000_A5A5, A_DIR, 32'h0000_0180, 22'h00A5A5, 22'h0, 8'd2},
    // R3: keep upper byte of low half, value low byte
    '{A_LO,  32'hFF00_00FF, A_LO,  32'h0,         22'h00A5FF, 22'h0, 8'd3},
    // R3: clear only pin 0
    '{A_LO,  32'hFFFE_0000, A_HI,  32'h0,         22'h00A5FE, 22'h0, 8'd3},
    // R4: high window, only 16..21 implemented
    '{A_HI,  32'h0000_FFFF, A_B1W, 32'h0,         22'h3FA5FE, 22'h0, 8'd4},
    // R4: clear pin 21 only
    '{A_HI,  32'hFFDF_0000, A_OE,  32'h0,         22'h1FA5FE, 22'h0, 8'd4},
    // R9: all-ones dir keeps only implemented bits
    '{A_DIR, 32'hFFFF_FFFF, A_DIR, 32'h003F_FFFF, 22'h1FA5FE, 22'h0, 8'd9},
    // R7: clearing dir keeps pins 7 and 8
    '{A_DIR, 32'h0000_0000, A_DIR, 32'h0000_0180, 22'h1FA5FE, 22'h0, 8'd7},
    // R6: oe with dir only on 7,8 -> drive pin 7
    '{A_OE,  32'h0000_F0F0, A_OE,  32'h0000_F0F0, 22'h1FA5FE, 22'h000080, 8'd6},
    // R10: unmapped write ignored
    '{A_UNM, 32'h0000_0000, A_DIR, 32'h0000_0180, 22'h1FA5FE, 22'h000080, 8'd10},
    // R10: other bank's window ignored
    '{A_B1W, 32'h0000_0000, A_OE,  32'h0000_F0F0, 22'h1FA5FE, 22'h000080, 8'd10}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .BANK_ID(0), .ADDR_W(AW)) u0 (
    .clk, .rst, .addr, .wr_en, .wr_data, .rd_data, .pin_in, .pin_out, .pin_oe
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write on one edge, then present the read address; sample after its edge.
  task automatic wr_then_rd(logic [AW-1:0] wa, logic [31:0] wd, logic [AW-1:0] ra);
    addr = wa; wr_data = wd; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = ra;
    @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] ra);
    addr = ra;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    rd(A_DIR); check("R1 dir", rd_data, 32'h0000_0180);
    rd(A_OE);  check("R1 oe", rd_data, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      wr_then_rd(VECS[i].waddr, VECS[i].wdata, VECS[i].raddr);
      check({tag, " rd"}, rd_data, VECS[i].rexp);
      check({tag, " out"}, 32'(pin_out), 32'(VECS[i].pexp));
      check({tag, " oe"}, 32'(pin_oe), 32'(VECS[i].oexp));
    end

    // R8/R11: level goes through two flops then the read register
    addr = A_LVL;
    pin_in = 22'h2A_AAAA;
    @(negedge clk); check("R8 after 1 edge", rd_data, 32'h0);
    @(negedge clk); check("R8 after 2 edges", rd_data, 32'h0);
    @(negedge clk); check("R8 after 3 edges", rd_data, 32'h002A_AAAA);
    // R9: all pins high, nothing above pin 21
    pin_in = '1;
    repeat (3) @(negedge clk);
    check("R9 level", rd_data, 32'h003F_FFFF);

    // R5/R6: drive enable follows dir AND oe
    wr_then_rd(A_DIR, 32'h003F_FFFF, A_DIR);
    check("R5 dir", rd_data, 32'h003F_FFFF);
    wr_then_rd(A_OE, 32'h0000_0F0F, A_OE);
    check("R5 oe", rd_data, 32'h0000_0F0F);
    check("R6 both", 32'(pin_oe), 32'h0000_0F0F);
    wr_then_rd(A_DIR, 32'h0000_0000, A_DIR);
    check("R6 dir cleared", 32'(pin_oe), 32'h0000_0100);
    check("R7 dir", rd_data, 32'h0000_0180);

    // R2/R3: set single pin 3 without touching others
    wr_then_rd(A_LO, 32'hFFF7_0008, A_LO);
    check("R2 single set", 32'(pin_out), 32'h001F_A5FE);
    wr_then_rd(A_LO, 32'hFFFD_0000, A_LO);
    check("R3 single clear", 32'(pin_out), 32'h001F_A5FC);
    check("R10 window rd", rd_data, 32'h0);

    // R1: reset again clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 re-reset out", 32'(pin_out), 32'h0);
    check("R1 re-reset oe", 32'(pin_oe), 32'h0);
    rd(A_OE); check("R1 re-reset oe reg", rd_data, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule